// File: doc/BRIEF.md
# Power-Management Companion Register Bank

This block is the register file of a power-management companion chip. A serial bus slave elsewhere in the chip decodes frames and presents each access on a simple parallel port. The port carries a write strobe, a 5-bit register index and 16 bits of write data. Read data is returned combinationally for whatever index is presented, and reads have no side effects.

The bank keeps an interrupt status word and an interrupt mask, and it drives a level interrupt line from them. Writes to the status word toggle bits rather than clear them. A mask bit of 1 blocks its source.

It also holds the following registers:
- An ADC channel selector whose read-back pairs the channel with a fixed, preset conversion result.
- A sample-control word whose bits are cleared by writing ones.
- A calibration word and two general control words.
- A power-status word that follows a power-key input.
- A watchdog register that can request a system shutdown.

Registers that are not implemented read zero and discard writes.

Top module: `pmic_regbank`

## Requirements
- R1: After reset the mask reads 0xFFFF, the interrupt status reads 0x0000, the power-status word (index 0x16) reads 0x0020, the calibration word (index 0x06) reads 0x0001, the sample-control word (index 0x09) reads 0xFFFF, and both the interrupt and shutdown outputs are low.
- R2: The interrupt output is high exactly when some bit is set both in the status word and as zero in the mask.
- R3: A write to index 0x01 XORs the written value into the interrupt status on the next clock edge. A read of 0x01 returns the raw status.
- R4: Index 0x02 is the mask, fully readable and writable.
- R5: Index 0x00 reads 0x0215, with bit 7 additionally set while the variant strap input is high. Writes to it change nothing.
- R6: A write to index 0x08 latches write bits [13:10] as the ADC channel and sets interrupt status bit 8. A read of 0x08 returns the channel in bits [13:10], the channel's 10-bit result in bits [9:0], and zero in bits [15:14].
- R7: The preset results include channel 1 = 0x3C2, channel 8 = 0x250 and channel 13 = 0x330. Channels 0, 9, 14 and 15 have no preset and give a result of zero.
- R8: A write to index 0x09 clears every sample-control bit written as one and keeps the rest.
- R9: The calibration word (0x06) and the two control words (0x0D, 0x0E) store and return any written value.
- R10: Writing 0x0000 to index 0x17 raises the shutdown output for exactly one cycle after the write edge, and only while bit 1 of control word 0x0D is set. A nonzero value written there, or a zero written with that bit clear, gives no pulse.
- R11: A one-cycle key pulse sets interrupt status bit 0 and sets power-status bit 5 to the inverse of the key-state input, both on the next clock edge. Writes to index 0x16 are ignored.
- R12: Unimplemented indices (for example 0x03 and 0x1F) read 0x0000 and ignore writes.
- R13: When an event (key pulse or ADC channel write) lands in the same cycle as a status toggle write, the event's bit ends up set, whatever the toggle did to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| acc_wr | input | 1 | Write strobe for the current index |
| acc_index | input | 5 | Register index |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data for acc_index |
| variant_strap | input | 1 | Variant strap, reflected in the ID word |
| key_pulse | input | 1 | One-cycle power-key event |
| key_state | input | 1 | Power-key level sampled with key_pulse |
| irq_out | output | 1 | Level interrupt request |
| shutdown_req | output | 1 | One-cycle shutdown request |

## Verification
The interrupt path is driven with toggle patterns that set, partly clear and fully clear the status. Each pattern is applied under a closed mask and again under a mask open on one bit, so that toggle semantics are told apart from write-one-to-clear, and mask polarity is pinned down.

The ADC selector is swept over preset channels, unpreset channels and a write with every bit high. This separates correct field placement from stray data bits leaking in.

The watchdog is written with zero and with nonzero values, each with the enable bit both clear and set. The key input is pulsed in both states. A key pulse is also made to coincide with a toggle write on the same bit, to confirm that the event has priority.

// File: rtl/pmic_pkg.sv
package pmic_pkg;
    localparam int DW = 16;
    localparam int AW = 5;

    localparam logic [AW-1:0] IX_ID    = 5'h00;
    localparam logic [AW-1:0] IX_ISTAT = 5'h01;
    localparam logic [AW-1:0] IX_IMASK = 5'h02;
    localparam logic [AW-1:0] IX_CAL   = 5'h06;
    localparam logic [AW-1:0] IX_ADC   = 5'h08;
    localparam logic [AW-1:0] IX_SAMP  = 5'h09;
    localparam logic [AW-1:0] IX_CTL1  = 5'h0D;
    localparam logic [AW-1:0] IX_CTL2  = 5'h0E;
    localparam logic [AW-1:0] IX_PSTAT = 5'h16;
    localparam logic [AW-1:0] IX_WDOG  = 5'h17;

    localparam int IRQ_KEY_BIT = 0;
    localparam int IRQ_ADC_BIT = 8;
    localparam int PSTAT_KEY_BIT = 5;
    localparam int WDOG_EN_BIT = 1;
    localparam int STRAP_BIT = 7;
endpackage

// File: rtl/pmic_irq_ctrl.sv
module pmic_irq_ctrl #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stat,
    input  logic          wr_mask,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] set_vec,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] mask_q,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0] stat;
        logic [DW-1:0] mask;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stat) st_d.stat = st_q.stat ^ wdata;
        st_d.stat = st_d.stat | set_vec;
        if (wr_mask) st_d.mask = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stat <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q = st_q.stat;
    assign mask_q = st_q.mask;
    assign irq    = |(st_q.stat & ~st_q.mask);

    // R3
    toggle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && set_vec == '0) |=> stat_q == ($past(stat_q) ^ $past(wdata)));

    // R2
    mask_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && wdata == '1) |=> !irq);

    // R13
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/pmic_adc.sv
module pmic_adc #(
    parameter int          DW = 16,
    parameter int          CH_W = 4,
    parameter int          RES_W = 10,
    parameter logic [15:0] SAMPLE_INIT = 16'hFFFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_sel,
    input  logic            wr_samp,
    input  logic [CH_W-1:0] sel_wdata,
    input  logic [DW-1:0]   samp_wdata,
    output logic [DW-1:0]   sel_rd,
    output logic [DW-1:0]   samp_rd,
    output logic            done_evt
);
    localparam int PAD_W = DW - CH_W - RES_W;

    typedef struct packed {
        logic [CH_W-1:0] ch;
        logic [DW-1:0]   samp;
    } adc_st_t;

    adc_st_t st_d, st_q;

    function automatic logic [RES_W-1:0] preset(input logic [CH_W-1:0] c);
        case (c)
            4'd1:    preset = RES_W'(10'h3C2);
            4'd2:    preset = RES_W'(10'h0FC);
            4'd3:    preset = RES_W'(10'h165);
            4'd4:    preset = RES_W'(10'h07B);
            4'd5:    preset = RES_W'(10'h3FF);
            4'd6:    preset = RES_W'(10'h011);
            4'd7:    preset = RES_W'(10'h011);
            4'd8:    preset = RES_W'(10'h250);
            4'd10:   preset = RES_W'(10'h002);
            4'd11:   preset = RES_W'(10'h011);
            4'd12:   preset = RES_W'(10'h3D0);
            4'd13:   preset = RES_W'(10'h330);
            default: preset = '0;
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_sel)  st_d.ch   = sel_wdata;
        if (wr_samp) st_d.samp = st_q.samp & ~samp_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ch   <= '0;
            st_q.samp <= DW'(SAMPLE_INIT);
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_rd   = {{PAD_W{1'b0}}, st_q.ch, preset(st_q.ch)};
    assign samp_rd  = st_q.samp;
    assign done_evt = wr_sel;

    // R6
    chan_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> sel_rd[RES_W +: CH_W] == $past(sel_wdata));

    // R8
    samp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_samp |=> (samp_rd & $past(samp_wdata)) == '0);
endmodule

// File: rtl/pmic_regbank.sv
module pmic_regbank
    import pmic_pkg::*;
#(
    parameter logic [15:0] ID_BASE = 16'h0215,
    parameter logic [15:0] CAL_INIT = 16'h0001,
    parameter logic [15:0] PSTAT_INIT = 16'h0020,
    parameter logic [15:0] SAMPLE_INIT = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_index,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] acc_rdata,
    input  logic          variant_strap,
    input  logic          key_pulse,
    input  logic          key_state,
    output logic          irq_out,
    output logic          shutdown_req
);
    localparam int CH_W = 4;
    localparam int RES_W = 10;

    typedef struct packed {
        logic [DW-1:0] cal;
        logic [DW-1:0] ctl1;
        logic [DW-1:0] ctl2;
        logic [DW-1:0] pstat;
        logic          sdn;
    } misc_st_t;

    misc_st_t st_d, st_q;

    logic [DW-1:0] istat, imask, adc_rd, samp_rd, evt;
    logic          adc_done;

    wire hit_istat = acc_wr && acc_index == IX_ISTAT;
    wire hit_imask = acc_wr && acc_index == IX_IMASK;
    wire hit_adc   = acc_wr && acc_index == IX_ADC;
    wire hit_samp  = acc_wr && acc_index == IX_SAMP;

    always_comb begin
        evt = '0;
        evt[IRQ_KEY_BIT] = key_pulse;
        evt[IRQ_ADC_BIT] = adc_done;
    end

    pmic_irq_ctrl #(.DW(DW)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stat (hit_istat),
        .wr_mask (hit_imask),
        .wdata   (acc_wdata),
        .set_vec (evt),
        .stat_q  (istat),
        .mask_q  (imask),
        .irq     (irq_out)
    );

    pmic_adc #(
        .DW(DW), .CH_W(CH_W), .RES_W(RES_W), .SAMPLE_INIT(SAMPLE_INIT)
    ) u_adc (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (hit_adc),
        .wr_samp    (hit_samp),
        .sel_wdata  (acc_wdata[RES_W +: CH_W]),
        .samp_wdata (acc_wdata),
        .sel_rd     (adc_rd),
        .samp_rd    (samp_rd),
        .done_evt   (adc_done)
    );

    always_comb begin
        st_d = st_q;
        st_d.sdn = 1'b0;
        if (acc_wr) begin
            case (acc_index)
                IX_CAL:  st_d.cal  = acc_wdata;
                IX_CTL1: st_d.ctl1 = acc_wdata;
                IX_CTL2: st_d.ctl2 = acc_wdata;
                IX_WDOG: st_d.sdn  = (acc_wdata == '0) && st_q.ctl1[WDOG_EN_BIT];
                default: ;
            endcase
        end
        if (key_pulse) st_d.pstat[PSTAT_KEY_BIT] = ~key_state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cal   <= DW'(CAL_INIT);
            st_q.ctl1  <= '0;
            st_q.ctl2  <= '0;
            st_q.pstat <= DW'(PSTAT_INIT);
            st_q.sdn   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (acc_index)
            IX_ID:    acc_rdata = DW'(ID_BASE) | (DW'(variant_strap) << STRAP_BIT);
            IX_ISTAT: acc_rdata = istat;
            IX_IMASK: acc_rdata = imask;
            IX_CAL:   acc_rdata = st_q.cal;
            IX_ADC:   acc_rdata = adc_rd;
            IX_SAMP:  acc_rdata = samp_rd;
            IX_CTL1:  acc_rdata = st_q.ctl1;
            IX_CTL2:  acc_rdata = st_q.ctl2;
            IX_PSTAT: acc_rdata = st_q.pstat;
            default:  acc_rdata = '0;
        endcase
    end

    assign shutdown_req = st_q.sdn;

    // R10
    shutdown_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(acc_wr && acc_index == IX_WDOG &&
                               acc_wdata == '0 && st_q.ctl1[WDOG_EN_BIT]));

    // R10
    shutdown_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> !shutdown_req);

    // R11
    key_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_pulse |=> st_q.pstat[PSTAT_KEY_BIT] == !$past(key_state));
endmodule

// File: tb/sim_pmic_regbank.sv
module sim_pmic_regbank;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        acc_wr = 0;
    logic [4:0]  acc_index = 0;
    logic [15:0] acc_wdata = 0;
    logic [15:0] acc_rdata;
    logic        variant_strap = 0;
    logic        key_pulse = 0;
    logic        key_state = 0;
    logic        irq_out;
    logic        shutdown_req;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmic_regbank u0 (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_index(acc_index),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .variant_strap(variant_strap), .key_pulse(key_pulse),
        .key_state(key_state), .irq_out(irq_out), .shutdown_req(shutdown_req)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] ix, input logic [15:0] d);
        @(negedge clk);
        acc_wr = 1; acc_index = ix; acc_wdata = d;
        @(posedge clk);
        @(negedge clk);
        acc_wr = 0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] ix, input logic [15:0] exp);
        acc_index = ix;
        #1;
        chk(req, acc_rdata, exp);
    endtask

    task automatic key(input logic s);
        @(negedge clk);
        key_pulse = 1; key_state = s;
        @(posedge clk);
        @(negedge clk);
        key_pulse = 0;
    endtask

    task automatic t_reset;
        rd_chk("R1 mask", 5'h02, 16'hFFFF);
        rd_chk("R1 istat", 5'h01, 16'h0000);
        rd_chk("R1 pstat", 5'h16, 16'h0020);
        rd_chk("R1 cal", 5'h06, 16'h0001);
        rd_chk("R1 samp", 5'h09, 16'hFFFF);
        chk("R1 irq", {15'd0, irq_out}, 16'd0);
        chk("R1 sdn", {15'd0, shutdown_req}, 16'd0);
        rd_chk("R5 id", 5'h00, 16'h0215);
        variant_strap = 1;
        rd_chk("R5 id strap", 5'h00, 16'h0295);
        variant_strap = 0;
        wr(5'h00, 16'hFFFF);
        rd_chk("R5 id write ignored", 5'h00, 16'h0215);
    endtask

    task automatic t_irq;
        wr(5'h01, 16'h0005);
        rd_chk("R3 toggle set", 5'h01, 16'h0005);
        chk("R2 masked", {15'd0, irq_out}, 16'd0);
        wr(5'h02, 16'hFFFB);
        rd_chk("R4 mask rw", 5'h02, 16'hFFFB);
        chk("R2 open bit", {15'd0, irq_out}, 16'd1);
        wr(5'h01, 16'h0004);
        rd_chk("R3 toggle clear", 5'h01, 16'h0001);
        chk("R2 source gone", {15'd0, irq_out}, 16'd0);
        wr(5'h01, 16'h0003);
        rd_chk("R3 toggle mixed", 5'h01, 16'h0002);
        wr(5'h01, 16'h0002);
        rd_chk("R3 zero", 5'h01, 16'h0000);
    endtask

    task automatic t_adc;
        wr(5'h02, 16'hFEFF);
        wr(5'h08, 16'h0400);
        rd_chk("R6 R7 ch1", 5'h08, 16'h07C2);
        rd_chk("R6 done bit", 5'h01, 16'h0100);
        chk("R2 adc irq", {15'd0, irq_out}, 16'd1);
        wr(5'h01, 16'h0100);
        chk("R2 adc cleared", {15'd0, irq_out}, 16'd0);
        wr(5'h08, 16'h2000);
        rd_chk("R7 ch8", 5'h08, 16'h2250);
        wr(5'h08, 16'h3400);
        rd_chk("R7 ch13", 5'h08, 16'h3730);
        wr(5'h08, 16'h0000);
        rd_chk("R7 ch0", 5'h08, 16'h0000);
        wr(5'h08, 16'h2400);
        rd_chk("R7 ch9", 5'h08, 16'h2400);
        wr(5'h08, 16'h3800);
        rd_chk("R7 ch14", 5'h08, 16'h3800);
        wr(5'h08, 16'hFFFF);
        rd_chk("R6 field only", 5'h08, 16'h3C00);
        wr(5'h01, 16'h0100);
        wr(5'h02, 16'hFFFF);
    endtask

    task automatic t_regs;
        wr(5'h09, 16'h00F0);
        rd_chk("R8 clear ones", 5'h09, 16'hFF0F);
        wr(5'h09, 16'h0000);
        rd_chk("R8 zero keeps", 5'h09, 16'hFF0F);
        wr(5'h06, 16'h1234);
        rd_chk("R9 cal", 5'h06, 16'h1234);
        wr(5'h0D, 16'hA5A4);
        rd_chk("R9 ctl1", 5'h0D, 16'hA5A4);
        wr(5'h0E, 16'h5A5A);
        rd_chk("R9 ctl2", 5'h0E, 16'h5A5A);
        wr(5'h03, 16'hABCD);
        rd_chk("R12 idx03", 5'h03, 16'h0000);
        wr(5'h1F, 16'h1111);
        rd_chk("R12 idx1F", 5'h1F, 16'h0000);
        wr(5'h16, 16'h0000);
        rd_chk("R11 pstat write ignored", 5'h16, 16'h0020);
    endtask

    task automatic t_wdog;
        wr(5'h17, 16'h0000);
        chk("R10 bit clear no pulse", {15'd0, shutdown_req}, 16'd0);
        wr(5'h0D, 16'h0002);
        wr(5'h17, 16'h0005);
        chk("R10 nonzero no pulse", {15'd0, shutdown_req}, 16'd0);
        wr(5'h17, 16'h0000);
        chk("R10 pulse", {15'd0, shutdown_req}, 16'd1);
        @(negedge clk);
        chk("R10 one cycle", {15'd0, shutdown_req}, 16'd0);
    endtask

    task automatic t_key;
        key(1'b1);
        rd_chk("R11 pressed", 5'h16, 16'h0000);
        rd_chk("R11 key irq", 5'h01, 16'h0001);
        key(1'b0);
        rd_chk("R11 released", 5'h16, 16'h0020);
        @(negedge clk);
        acc_wr = 1; acc_index = 5'h01; acc_wdata = 16'h0001;
        key_pulse = 1; key_state = 1;
        @(posedge clk);
        @(negedge clk);
        acc_wr = 0; key_pulse = 0;
        rd_chk("R13 event wins", 5'h01, 16'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_irq();
        t_adc();
        t_regs();
        t_wdog();
        t_key();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog expired got=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule